// File: doc/BRIEF.md
# Serial port with three-sample majority receive on an APB slave

This block is a serial port for a processor subsystem. A processor reaches it through an APB3 slave port. A transmit FIFO and a receive FIFO, each sixteen bytes deep, sit between the bus and the serial line. One level-sensitive interrupt output is meant for the processor's external interrupt input.

The frame is always one start bit, eight data bits sent least significant bit first, no parity and one stop bit. The baud divider is also set when the block is built. Neither can be changed from the bus; a read-only register reports both.

A free-running divider makes a sampling tick, and every serial bit lasts exactly five ticks. On receive, the first tick of a bit is a lead-in and the last tick is a tail. The bit value is the 2-of-3 majority of the three ticks in between. A short glitch on the line therefore does not corrupt a byte. A start bit that does not hold low for the vote is discarded. A stop bit that votes low drops the byte and records a framing error.

Top module: `apb_uart_vote`

## Requirements
- R1: The divider value is round(CLK_HZ / (BAUD × 5)) − 1, which is 20 for 12 MHz and 115200 baud. A sampling tick occurs every divider+1 clocks. Word offset 0x08 reads the divider in bits [19:0] and the data length code (data bits − 1, so 7) in bits [22:20]; all other bits read 0.
- R2: Writes to offset 0x08 have no effect. A read of offset 0x08 returns the same value after such a write, and the serial bit time stays the same.
- R3: txd idles high. A frame is a low start bit, 8 data bits least significant bit first, and a high stop bit. Each bit lasts exactly 5 ticks. When the TX FIFO holds more bytes, frames follow back to back with no idle gap.
- R4: rxd passes through a two-flop synchronizer. Each received bit is the 2-of-3 majority of its 2nd, 3rd and 4th ticks, so a line disturbance that covers at most one tick does not change the byte.
- R5: A low pulse on rxd that does not win the start-bit majority is discarded. No byte is stored, and the receiver is ready for the next frame.
- R6: If the stop bit votes 0, the byte is not stored and the sticky framing flag (status bit 24) is set. Writing 1 to status bit 24 clears the flag.
- R7: A read of offset 0x00 returns bit 16 = 1 and the oldest received byte in bits [7:0], and removes that byte from the RX FIFO. When the RX FIFO is empty the read returns 0.
- R8: A write to offset 0x00 pushes pwdata[7:0] into the 16-entry TX FIFO. A write to a full TX FIFO is dropped. Status bits [15:8] give the number of free TX entries.
- R9: The RX FIFO holds 16 bytes, and status bits [23:16] give its occupancy. A byte that arrives while the FIFO is full is dropped and sets the sticky overrun flag (status bit 25). Writing 1 to status bit 25 clears the flag.
- R10: Status bit 0 enables the TX-empty interrupt and status bit 1 enables the RX-data interrupt; both are writable at offset 0x04. irq = (bit0 AND TX FIFO empty) OR (bit1 AND RX FIFO not empty).
- R11: After reset, txd = 1 and irq = 0. The status register reads 0x00001000: both enables 0, both flags 0, 16 TX entries free and no RX bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and core clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several receive corner cases, each checked by reading the byte or the status afterwards:
- A mid-bit glitch short enough to reach only one voting tick. A receiver that samples once instead of voting would flip that bit.
- A false start pulse of about one tick. A receiver that commits on the first low sample would store a phantom byte.
- A stop bit held low. A receiver that ignores the stop vote would store the byte and leave the framing flag clear.
- Seventeen frames without reads. The seventeenth must be dropped and must set the overrun flag; a FIFO that wraps would overwrite the oldest byte.

On transmit, the bench fills the FIFO past its depth. The extra write must never appear on the line. The length of the start bit is measured to the clock, so a divider off by one shows up at once. Frames are compared in order against a queue of expected bytes.

// File: rtl/uart_vote_pkg.sv
package uart_vote_pkg;

  // Ticks per serial bit: one lead-in, three voting, one tail.
  localparam int unsigned TICKS_PER_BIT = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } line_state_e;

  // Register word indices (byte offset / 4).
  localparam int unsigned WORD_DATA = 0;
  localparam int unsigned WORD_STAT = 1;
  localparam int unsigned WORD_CFG  = 2;

  // Rounded divider reload value for the tick counter.
  function automatic int unsigned baud_divider(input int unsigned clk_hz,
                                               input int unsigned baud);
    int unsigned den;
    den = baud * TICKS_PER_BIT;
    return ((2 * clk_hz + den) / (2 * den)) - 1;
  endfunction

  // Two-of-three majority.
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_vote_tick.sv
module uart_vote_tick #(
  parameter int unsigned DIV_W  = 20,
  parameter int unsigned RELOAD = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam logic [DIV_W-1:0] LOAD_VAL = DIV_W'(RELOAD);

  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= LOAD_VAL;
    else if (tick) cnt <= LOAD_VAL;
    else           cnt <= cnt - DIV_W'(1);
  end
endmodule

// File: rtl/uart_vote_fifo.sv
module uart_vote_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
  import uart_vote_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rxd,
  output logic                 byte_valid,
  output logic                 frame_err,
  output logic [DATA_BITS-1:0] byte_data
);
  logic        sync_a, line;
  line_state_e state;
  logic [2:0]  phase, cur;
  logic [1:0]  votes;
  logic        decided;
  logic [IW-1:0] idx;
  logic [DATA_BITS-1:0] shreg;

  // Tick index inside the bit: 0 lead-in, 1..3 voting, 4 tail.
  assign cur       = (phase == 3'd4) ? 3'd0 : phase + 3'd1;
  assign decided   = vote3(votes[0], votes[1], line);
  assign byte_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b1;
      line   <= 1'b1;
    end else begin
      sync_a <= rxd;
      line   <= sync_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      phase      <= '0;
      votes      <= '0;
      idx        <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
      if (tick) begin
        if (state == ST_IDLE) begin
          if (!line) begin
            state <= ST_START;
            phase <= 3'd0;
          end
        end else begin
          phase <= cur;
          case (cur)
            3'd1: votes[0] <= line;
            3'd2: votes[1] <= line;
            3'd3: begin
              case (state)
                ST_START: if (decided) state <= ST_IDLE;
                ST_DATA:  shreg <= {decided, shreg[DATA_BITS-1:1]};
                ST_STOP: begin
                  state <= ST_IDLE;
                  if (decided) byte_valid <= 1'b1;
                  else         frame_err  <= 1'b1;
                end
                default: ;
              endcase
            end
            3'd0: begin
              case (state)
                ST_START: begin
                  state <= ST_DATA;
                  idx   <= '0;
                end
                ST_DATA: begin
                  if (idx == IW'(DATA_BITS - 1)) state <= ST_STOP;
                  else                           idx   <= idx + IW'(1);
                end
                default: ;
              endcase
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/uart_vote_tx.sv
module uart_vote_tx
  import uart_vote_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 have_data,
  input  logic [DATA_BITS-1:0] data,
  output logic                 load,
  output logic                 txd
);
  line_state_e          state;
  logic [2:0]           phase;
  logic [IW-1:0]        idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 bit_end;

  assign bit_end = (phase == 3'd4);
  assign load    = tick && have_data &&
                   ((state == ST_IDLE) || (state == ST_STOP && bit_end));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phase <= '0;
      idx   <= '0;
      shreg <= '0;
      txd   <= 1'b1;
    end else if (tick) begin
      if (load) begin
        state <= ST_START;
        phase <= 3'd0;
        shreg <= data;
        txd   <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (!bit_end) begin
          phase <= phase + 3'd1;
        end else begin
          phase <= 3'd0;
          case (state)
            ST_START: begin
              state <= ST_DATA;
              idx   <= '0;
              txd   <= shreg[0];
            end
            ST_DATA: begin
              if (idx == IW'(DATA_BITS - 1)) begin
                state <= ST_STOP;
                txd   <= 1'b1;
              end else begin
                idx   <= idx + IW'(1);
                shreg <= shreg >> 1;
                txd   <= shreg[1];
              end
            end
            ST_STOP: begin
              state <= ST_IDLE;
              txd   <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/apb_uart_vote.sv
module apb_uart_vote
  import uart_vote_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 12_000_000,
  parameter int unsigned BAUD       = 115_200,
  parameter int unsigned DIV_W      = 20,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned DATA_BITS  = 8,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic              rxd,
  output logic              txd,
  output logic              irq
);
  localparam int unsigned DIVIDER  = baud_divider(CLK_HZ, BAUD);
  localparam int unsigned CNT_W    = $clog2(FIFO_DEPTH + 1);
  localparam logic [2:0]  LEN_CODE = 3'(DATA_BITS - 1);

  logic                 tick;
  logic [ADDR_W-3:0]    word;
  logic                 access, bus_wr, bus_rd;
  logic                 sel_data, sel_stat;
  logic                 tx_push, tx_pop, tx_full, tx_empty;
  logic                 rx_pop, rx_full, rx_empty;
  logic [CNT_W-1:0]     tx_count, rx_count, tx_free;
  logic [DATA_BITS-1:0] tx_head, rx_head, rx_byte;
  logic                 rx_byte_valid, rx_frame_err;
  logic                 ie_tx, ie_rx, fe_flag, ovr_flag;
  logic                 unused_bits;

  assign pready   = 1'b1;
  assign word     = paddr[ADDR_W-1:2];
  assign access   = psel && penable;
  assign bus_wr   = access && pwrite;
  assign bus_rd   = access && !pwrite;
  assign sel_data = (word == (ADDR_W-2)'(WORD_DATA));
  assign sel_stat = (word == (ADDR_W-2)'(WORD_STAT));
  assign tx_push  = bus_wr && sel_data;
  assign rx_pop   = bus_rd && sel_data;
  assign tx_free  = CNT_W'(FIFO_DEPTH) - tx_count;
  assign unused_bits = ^{paddr[1:0], pwdata[31:26], pwdata[23:8]};

  uart_vote_tick #(.DIV_W(DIV_W), .RELOAD(DIVIDER)) tick_i (
    .clk(pclk), .rst_n(presetn), .tick(tick)
  );

  uart_vote_fifo #(.W(DATA_BITS), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk(pclk), .rst_n(presetn),
    .push(tx_push), .wdata(pwdata[DATA_BITS-1:0]),
    .pop(tx_pop), .rdata(tx_head),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  uart_vote_fifo #(.W(DATA_BITS), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk(pclk), .rst_n(presetn),
    .push(rx_byte_valid), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  uart_vote_tx #(.DATA_BITS(DATA_BITS)) tx_i (
    .clk(pclk), .rst_n(presetn), .tick(tick),
    .have_data(!tx_empty), .data(tx_head),
    .load(tx_pop), .txd(txd)
  );

  uart_vote_rx #(.DATA_BITS(DATA_BITS)) rx_i (
    .clk(pclk), .rst_n(presetn), .tick(tick), .rxd(rxd),
    .byte_valid(rx_byte_valid), .frame_err(rx_frame_err),
    .byte_data(rx_byte)
  );

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ie_tx    <= 1'b0;
      ie_rx    <= 1'b0;
      fe_flag  <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (bus_wr && sel_stat) begin
        ie_tx <= pwdata[0];
        ie_rx <= pwdata[1];
        if (pwdata[24]) fe_flag  <= 1'b0;
        if (pwdata[25]) ovr_flag <= 1'b0;
      end
      if (rx_frame_err)            fe_flag  <= 1'b1;
      if (rx_byte_valid && rx_full) ovr_flag <= 1'b1;
    end
  end

  assign irq = (ie_tx && tx_empty) || (ie_rx && !rx_empty);

  always_comb begin
    case (word)
      (ADDR_W-2)'(WORD_DATA):
        prdata = {15'd0, !rx_empty, 8'd0, rx_empty ? 8'd0 : 8'(rx_head)};
      (ADDR_W-2)'(WORD_STAT):
        prdata = {6'd0, ovr_flag, fe_flag, 8'(rx_count), 8'(tx_free),
                  6'd0, ie_rx, ie_tx};
      (ADDR_W-2)'(WORD_CFG):
        prdata = {9'd0, LEN_CODE, 20'(DIVIDER)};
      default:
        prdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/uart_vote_chk.sv
module uart_vote_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5,
  parameter int unsigned DIV   = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          txd,
  input logic          irq,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          tx_full,
  input logic          tx_push,
  input logic          tx_pop,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          rx_full,
  input logic          frame_err,
  input logic          ovr_flag,
  input logic          ie_tx,
  input logic          ie_rx
);
  logic [31:0] gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 32'd1;
    end
  end

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen) |-> (gap == DIV));

  assert_txd_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(txd));

  assert_frame_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !rx_pop) |=> (rx_count == $past(rx_count)));

  assert_tx_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_full && !tx_pop) |=> (tx_count == $past(tx_count)));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  assert_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> ovr_flag);

  assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((ie_tx && tx_count == '0) || (ie_rx && rx_count != '0)));
endmodule

bind apb_uart_vote uart_vote_chk #(
  .DEPTH(FIFO_DEPTH), .CW(CNT_W), .DIV(DIVIDER)
) chk_i (
  .clk(pclk), .rst_n(presetn), .tick(tick), .txd(txd), .irq(irq),
  .tx_count(tx_count), .rx_count(rx_count), .tx_full(tx_full),
  .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_byte_valid),
  .rx_pop(rx_pop), .rx_full(rx_full), .frame_err(rx_frame_err),
  .ovr_flag(ovr_flag), .ie_tx(ie_tx), .ie_rx(ie_rx)
);

// File: tb/apb_uart_vote_tb_top.sv
`timescale 1ns/1ps
module apb_uart_vote_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int F_CLK      = 12_000_000;
  localparam int F_BAUD     = 115_200;
  // Rounded divider restated: tenths, then round half up.
  localparam int DIV_EXP    = ((F_CLK * 10 / (F_BAUD * 5)) + 5) / 10 - 1;
  localparam int BIT_CLKS   = (DIV_EXP + 1) * 5;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        rxd = 1'b1;
  logic        txd;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit mon_en = 0;
  logic [7:0] tx_exp [$];

  apb_uart_vote dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .rxd(rxd), .txd(txd), .irq(irq)
  );

  always #(CLK_PERIOD/2) pclk = ~pclk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge pclk);
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk);
    penable = 1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  // Driver: accepted bytes go to the scoreboard queue.
  task automatic send_tx(input logic [7:0] b, input bit expect_sent);
    apb_wr(12'h000, {24'd0, b});
    if (expect_sent) tx_exp.push_back(b);
  endtask

  // Drive one frame on rxd; optional one-tick glitch inside bit gl (0 = start).
  task automatic send_rx(input logic [7:0] b, input bit stop_v, input int gl);
    logic [9:0] bits;
    bits = {stop_v, b, 1'b0};
    for (int n = 0; n < 10; n++) begin
      @(negedge pclk);
      rxd = bits[n];
      if (n == gl) begin
        wait_clks(BIT_CLKS/2 - 7);
        rxd = ~bits[n];
        wait_clks(15);
        rxd = bits[n];
        wait_clks(BIT_CLKS - (BIT_CLKS/2 - 7) - 15 - 1);
      end else begin
        wait_clks(BIT_CLKS - 1);
      end
    end
    @(negedge pclk);
    rxd = 1'b1;
  endtask

  // Monitor: decode txd frames and compare with the queue.
  initial begin
    logic [9:0] smp;
    int run;
    bit ended;
    logic [7:0] got;
    logic [7:0] want;
    wait (mon_en);
    forever begin
      @(negedge pclk);
      if (txd === 1'b0) begin
        run = 0; ended = 0; smp = '0;
        for (int k = 0; k <= BIT_CLKS/2 + 9*BIT_CLKS; k++) begin
          if (!ended) begin
            if (txd === 1'b0) run++;
            else ended = 1;
          end
          if (k >= BIT_CLKS/2 && ((k - BIT_CLKS/2) % BIT_CLKS) == 0)
            smp[(k - BIT_CLKS/2) / BIT_CLKS] = txd;
          if (k != BIT_CLKS/2 + 9*BIT_CLKS) @(negedge pclk);
        end
        got = smp[8:1];
        check(smp[0] == 1'b0, "R3 start bit low", int'(smp[0]), 0);
        check(smp[9] == 1'b1, "R3 stop bit high", int'(smp[9]), 1);
        if (tx_exp.size() == 0) begin
          check(0, "R8 unexpected frame on txd", int'(got), -1);
        end else begin
          want = tx_exp.pop_front();
          check(got == want, "R3 tx byte", int'(got), int'(want));
          if (want[0])
            check(run == BIT_CLKS, "R1 start bit length in clocks", run, BIT_CLKS);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    wait_clks(5);
    presetn = 1'b1;
    wait_clks(2);
    mon_en = 1;

    // Reset state
    check(txd === 1'b1, "R11 txd after reset", int'(txd), 1);
    check(irq === 1'b0, "R11 irq after reset", int'(irq), 0);
    check(pready === 1'b1, "R11 pready", int'(pready), 1);
    apb_rd(12'h004, d);
    check(d == 32'h0000_1000, "R11 status after reset", d, 32'h0000_1000);
    apb_rd(12'h000, d);
    check(d == 32'h0, "R7 read of empty RX", d, 0);

    // Fixed configuration
    apb_rd(12'h008, d);
    check(d == {9'd0, 3'd7, 20'(DIV_EXP)}, "R1 config word", d, {9'd0, 3'd7, 20'(DIV_EXP)});
    apb_wr(12'h008, 32'hFFFF_FFFF);
    apb_rd(12'h008, d);
    check(d == {9'd0, 3'd7, 20'(DIV_EXP)}, "R2 config after write", d, {9'd0, 3'd7, 20'(DIV_EXP)});

    // Transmit patterns (bit time also checked after the config write, R2)
    send_tx(8'h55, 1);
    send_tx(8'hA3, 1);
    send_tx(8'h00, 1);
    send_tx(8'hFF, 1);
    while (tx_exp.size() != 0) @(negedge pclk);
    wait_clks(2 * BIT_CLKS);

    // Interrupt enables
    apb_wr(12'h004, 32'h1);
    check(irq === 1'b1, "R10 irq tx-empty enabled", int'(irq), 1);
    apb_wr(12'h004, 32'h2);
    check(irq === 1'b0, "R10 irq rx enabled, rx empty", int'(irq), 0);

    // Plain receive
    send_rx(8'h3C, 1, -1);
    wait_clks(4);
    check(irq === 1'b1, "R10 irq rx data present", int'(irq), 1);
    apb_rd(12'h000, d);
    check(d == 32'h0001_003C, "R7 rx read", d, 32'h0001_003C);
    wait_clks(1);
    check(irq === 1'b0, "R10 irq after pop", int'(irq), 0);
    apb_rd(12'h000, d);
    check(d == 32'h0, "R7 rx empty after pop", d, 0);

    // Glitches confined to one voting tick
    send_rx(8'h00, 1, 4);
    send_rx(8'hFF, 1, 6);
    send_rx(8'h96, 1, 0);
    wait_clks(4);
    apb_rd(12'h000, d);
    check(d == 32'h0001_0000, "R4 glitch high in zero byte", d, 32'h0001_0000);
    apb_rd(12'h000, d);
    check(d == 32'h0001_00FF, "R4 glitch low in ones byte", d, 32'h0001_00FF);
    apb_rd(12'h000, d);
    check(d == 32'h0001_0096, "R4 glitch in start bit", d, 32'h0001_0096);

    // False start
    @(negedge pclk);
    rxd = 1'b0;
    wait_clks(22);
    rxd = 1'b1;
    wait_clks(12 * BIT_CLKS);
    apb_rd(12'h004, d);
    check(((d >> 16) & 32'hFF) == 0, "R5 no byte from false start", (d >> 16) & 32'hFF, 0);
    send_rx(8'h81, 1, -1);
    wait_clks(4);
    apb_rd(12'h000, d);
    check(d == 32'h0001_0081, "R5 frame after false start", d, 32'h0001_0081);

    // Framing error
    send_rx(8'h5A, 0, -1);
    wait_clks(2 * BIT_CLKS);
    apb_rd(12'h004, d);
    check(((d >> 16) & 32'hFF) == 0, "R6 bad frame not stored", (d >> 16) & 32'hFF, 0);
    check(d[24] == 1'b1, "R6 framing flag set", int'(d[24]), 1);
    apb_wr(12'h004, 32'h0100_0002);
    apb_rd(12'h004, d);
    check(d[24] == 1'b0, "R6 framing flag cleared", int'(d[24]), 0);

    // Overrun: 17 frames without reads
    for (int i = 0; i < 17; i++) send_rx(8'(8'h10 + i), 1, -1);
    wait_clks(4);
    apb_rd(12'h004, d);
    check(((d >> 16) & 32'hFF) == 16, "R9 rx occupancy full", (d >> 16) & 32'hFF, 16);
    check(d[25] == 1'b1, "R9 overrun flag set", int'(d[25]), 1);
    for (int i = 0; i < 16; i++) begin
      apb_rd(12'h000, d);
      check(d == (32'h0001_0000 | (32'h10 + i)), "R9 rx order after overrun",
            d, 32'h0001_0000 | (32'h10 + i));
    end
    apb_rd(12'h000, d);
    check(d == 32'h0, "R9 seventeenth byte dropped", d, 0);
    apb_wr(12'h004, 32'h0200_0000);
    apb_rd(12'h004, d);
    check(d[25] == 1'b0, "R9 overrun flag cleared", int'(d[25]), 0);

    // TX FIFO full: one byte moves to the shifter, 16 fill the FIFO
    for (int i = 0; i < 17; i++) send_tx(8'(i * 7 + 1), 1);
    apb_rd(12'h004, d);
    check(((d >> 8) & 32'hFF) == 0, "R8 tx free count at full", (d >> 8) & 32'hFF, 0);
    send_tx(8'hEE, 0);
    while (tx_exp.size() != 0) @(negedge pclk);
    wait_clks(3 * BIT_CLKS);
    apb_rd(12'h004, d);
    check(((d >> 8) & 32'hFF) == 16, "R8 tx free count drained", (d >> 8) & 32'hFF, 16);
    check(txd === 1'b1, "R3 txd idle after drain", int'(txd), 1);

    finish_run();
  end
endmodule